// File: doc/BRIEF.md
# Audio Receiver Interrupt and Error Handler

This block sits behind the front end of a digital audio interface receiver. It collects the receiver's live error and status flags and its one-cycle change events, and it drives two interrupt lines to the host. The first line reports link trouble: lock loss or a parity error. It is stretched by a selectable number of sample periods after the trouble ends, so that a brief glitch still gives the host a visible pulse. The second line reports stream-type changes: a non-PCM auto-detect or the audio/non-audio flag. It follows its events with no hold.

The same block guards the recovered audio. While lock is lost, the sample output is forced to zero and the validity output is held low. While a parity error is present and lock is held, the last good sample is repeated. A status byte shows the live flags and three sticky change flags. A read strobe from the host clears the sticky flags. Masks decide which flags may raise an interrupt, and they never hide a flag from the status byte.

Top module: `rx_event_irq`

## Requirements
- R1: `irqA` is high in the cycle after `lockLost` or `parErr` is present without its mask.
- R2: After all unmasked `lockLost`/`parErr` events clear, `irqA` stays high until the hold length's worth of `fsTick` strobes has been seen, and it is low in the cycle after the last of them. A reappearing event restarts the count from zero.
- R3: `holdSel` picks the hold length: 0 gives HOLD_0 (default 0, release in the cycle after clear), 1 gives HOLD_1 (default 384), 2 gives HOLD_2 (default 1024) and 3 gives HOLD_3 (default 4096) sample strobes.
- R4: `irqB` is high in the cycle after unmasked `nonPcm` or `audioFlag`, and low in the cycle after both have cleared or become masked.
- R5: `maskIn` bit 0 masks `lockLost`, bit 1 `parErr`, bit 2 `nonPcm` and bit 3 `audioFlag`. A 1 means masked, and the masked flag has no effect on `irqA`/`irqB`.
- R6: `status` bits 0 to 4 show `lockLost`, `parErr`, `nonPcm`, `audioFlag` and `validIn` live in the same cycle, whatever the masks.
- R7: `status` bits 5, 6 and 7 are sticky flags set by `qChgEv`, `csChgEv` and `detChgEv`. Each is 1 from the cycle after its event and is cleared in the cycle after a `rdStrobe`. During the read cycle it still shows its old value.
- R8: An event in the same cycle as `rdStrobe` leaves its sticky flag set.
- R9: While `lockLost` is 1, `sampleOut` is zero and `validOut` is 0 from the next cycle on, with or without `fsTick`.
- R10: With lock held and no parity error, an `fsTick` loads `sampleIn` into `sampleOut` for the next cycle. With lock held, `validOut` follows `validIn` one cycle later.
- R11: With lock held and `parErr` high, `sampleOut` keeps its value through `fsTick`.
- R12: After reset, `irqA`, `irqB`, `validOut`, `sampleOut` and the sticky flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fsTick | input | 1 | One-cycle sample-rate strobe |
| lockLost | input | 1 | Live lock-loss flag |
| parErr | input | 1 | Live parity-error flag |
| nonPcm | input | 1 | Live non-PCM auto-detect flag |
| audioFlag | input | 1 | Live audio/non-audio flag |
| validIn | input | 1 | Live validity flag |
| qChgEv | input | 1 | Q-subcode change pulse |
| csChgEv | input | 1 | Channel-status change pulse |
| detChgEv | input | 1 | Detection change pulse |
| maskIn | input | 4 | Interrupt masks, 1 = masked |
| holdSel | input | 2 | Hold length select for irqA |
| rdStrobe | input | 1 | Status read strobe |
| sampleIn | input | DATA_W | Incoming audio sample |
| irqA | output | 1 | Link-error interrupt, stretched |
| irqB | output | 1 | Stream-type interrupt, no hold |
| sampleOut | output | DATA_W | Guarded audio sample |
| validOut | output | 1 | Guarded validity |
| status | output | 8 | Live and sticky status flags |

## Verification
The bench builds the block with DATA_W = 16 and hold lengths of 0, 3, 8 and 20 strobes in place of 0, 384, 1024 and 4096. With these values, each hold can expire many times within a short run, and the release at every select value is checked. Holds can also be restarted part-way and cut short by a change of `holdSel`. The narrow sample width keeps the repeated-sample and zeroed-sample checks readable, and the control paths do not depend on it.

// File: rtl/rx_event_pkg.sv
package rx_event_pkg;
  // Strobes from control to datapath, evaluated each cycle.
  typedef struct packed {
    logic mute;       // lock lost: zero sample, drop validity
    logic load;       // take new sample on this strobe
    logic clrSticky;  // host read: clear sticky change flags
  } dpCmd_t;

  localparam int unsigned ST_LOCK  = 0;
  localparam int unsigned ST_PAR   = 1;
  localparam int unsigned ST_NPCM  = 2;
  localparam int unsigned ST_AUDIO = 3;
  localparam int unsigned ST_VALID = 4;
  localparam int unsigned ST_QCHG  = 5;
  localparam int unsigned ST_CSCHG = 6;
  localparam int unsigned ST_DET   = 7;
  localparam int unsigned ST_W     = 8;
endpackage

// File: rtl/rx_event_ctrl.sv
module rx_event_ctrl
  import rx_event_pkg::*;
#(
  parameter int unsigned HOLD_0 = 0,
  parameter int unsigned HOLD_1 = 384,
  parameter int unsigned HOLD_2 = 1024,
  parameter int unsigned HOLD_3 = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fsTick,
  input  logic       lockLost,
  input  logic       parErr,
  input  logic       nonPcm,
  input  logic       audioFlag,
  input  logic [3:0] maskIn,
  input  logic [1:0] holdSel,
  input  logic       rdStrobe,
  output logic       irqA,
  output logic       irqB,
  output dpCmd_t     cmd
);
  localparam int unsigned CNT_W = $clog2(HOLD_3 + 1);

  logic             actA, actB;
  logic [CNT_W-1:0] holdCnt, holdLen, cntNext;

  always_comb begin
    actA = (lockLost & ~maskIn[0]) | (parErr & ~maskIn[1]);
    actB = (nonPcm & ~maskIn[2]) | (audioFlag & ~maskIn[3]);
    cntNext = holdCnt + 1'b1;
    unique case (holdSel)
      2'd0:    holdLen = CNT_W'(HOLD_0);
      2'd1:    holdLen = CNT_W'(HOLD_1);
      2'd2:    holdLen = CNT_W'(HOLD_2);
      default: holdLen = CNT_W'(HOLD_3);
    endcase
  end

  // Stretched link-error line and its hold counter.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqA    <= 1'b0;
      holdCnt <= '0;
    end else if (actA) begin
      irqA    <= 1'b1;
      holdCnt <= '0;
    end else if (irqA) begin
      if (holdLen == '0) begin
        irqA    <= 1'b0;
        holdCnt <= '0;
      end else if (fsTick) begin
        if (cntNext >= holdLen) begin
          irqA    <= 1'b0;
          holdCnt <= '0;
        end else begin
          holdCnt <= cntNext;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqB <= 1'b0;
    else       irqB <= actB;
  end

  always_comb begin
    cmd.mute      = lockLost;
    cmd.load      = fsTick & ~lockLost & ~parErr;
    cmd.clrSticky = rdStrobe;
  end

  // R1
  irqa_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    actA |=> irqA);
  // R3
  irqa_zero_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!actA && holdSel == 2'd0) |=> !irqA);
  // R4
  irqb_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    actB |=> irqB);
  // R4
  irqb_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !actB |=> !irqB);
  // R2
  hold_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdCnt <= CNT_W'(HOLD_3)));
  // R2
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!actA && !fsTick && irqA && holdLen != '0) |=> irqA);
endmodule

// File: rtl/rx_event_dpath.sv
module rx_event_dpath
  import rx_event_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              validIn,
  input  logic              lockLost,
  input  logic              parErr,
  input  logic              nonPcm,
  input  logic              audioFlag,
  input  logic              qChgEv,
  input  logic              csChgEv,
  input  logic              detChgEv,
  output logic [DATA_W-1:0] sampleOut,
  output logic              validOut,
  output logic [ST_W-1:0]   status
);
  localparam int unsigned N_STK = 3;

  logic [N_STK-1:0] stkEv, stkFlag;

  assign stkEv = {detChgEv, csChgEv, qChgEv};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleOut <= '0;
      validOut  <= 1'b0;
    end else begin
      validOut <= validIn & ~cmd.mute;
      if (cmd.mute)      sampleOut <= '0;
      else if (cmd.load) sampleOut <= sampleIn;
    end
  end

  // One sticky cell per change event; an event beats a read.
  for (genvar i = 0; i < N_STK; i++) begin : g_stk
    always_ff @(posedge clk) begin
      if (!rstN) stkFlag[i] <= 1'b0;
      else       stkFlag[i] <= stkEv[i] | (stkFlag[i] & ~cmd.clrSticky);
    end
  end

  always_comb begin
    status           = '0;
    status[ST_LOCK]  = lockLost;
    status[ST_PAR]   = parErr;
    status[ST_NPCM]  = nonPcm;
    status[ST_AUDIO] = audioFlag;
    status[ST_VALID] = validIn;
    status[ST_QCHG]  = stkFlag[0];
    status[ST_CSCHG] = stkFlag[1];
    status[ST_DET]   = stkFlag[2];
  end

  // R9
  mute_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.mute |=> (sampleOut == '0 && !validOut));
  // R10
  load_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> (sampleOut == $past(sampleIn)));
  // R11
  keep_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.mute && !cmd.load) |=> $stable(sampleOut));
  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    qChgEv |=> status[ST_QCHG]);
  // R7
  sticky_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.clrSticky && !csChgEv) |=> !status[ST_CSCHG]);
endmodule

// File: rtl/rx_event_irq.sv
module rx_event_irq
  import rx_event_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned HOLD_0 = 0,
  parameter int unsigned HOLD_1 = 384,
  parameter int unsigned HOLD_2 = 1024,
  parameter int unsigned HOLD_3 = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fsTick,
  input  logic              lockLost,
  input  logic              parErr,
  input  logic              nonPcm,
  input  logic              audioFlag,
  input  logic              validIn,
  input  logic              qChgEv,
  input  logic              csChgEv,
  input  logic              detChgEv,
  input  logic [3:0]        maskIn,
  input  logic [1:0]        holdSel,
  input  logic              rdStrobe,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              irqA,
  output logic              irqB,
  output logic [DATA_W-1:0] sampleOut,
  output logic              validOut,
  output logic [7:0]        status
);
  dpCmd_t cmd;

  rx_event_ctrl #(
    .HOLD_0(HOLD_0), .HOLD_1(HOLD_1), .HOLD_2(HOLD_2), .HOLD_3(HOLD_3)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .fsTick(fsTick),
    .lockLost(lockLost), .parErr(parErr), .nonPcm(nonPcm),
    .audioFlag(audioFlag), .maskIn(maskIn), .holdSel(holdSel),
    .rdStrobe(rdStrobe), .irqA(irqA), .irqB(irqB), .cmd(cmd)
  );

  rx_event_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .sampleIn(sampleIn), .validIn(validIn),
    .lockLost(lockLost), .parErr(parErr), .nonPcm(nonPcm),
    .audioFlag(audioFlag), .qChgEv(qChgEv), .csChgEv(csChgEv),
    .detChgEv(detChgEv), .sampleOut(sampleOut), .validOut(validOut),
    .status(status)
  );
endmodule

// File: tb/sim_rx_event_irq.sv
module sim_rx_event_irq;
  localparam int DW = 16;
  localparam int H0 = 0, H1 = 3, H2 = 8, H3 = 20;

  logic clk = 1'b0, rstN = 1'b0;
  logic fsTick = 0, lockLost = 0, parErr = 0, nonPcm = 0, audioFlag = 0;
  logic validIn = 0, qChgEv = 0, csChgEv = 0, detChgEv = 0, rdStrobe = 0;
  logic [3:0] maskIn = '0;
  logic [1:0] holdSel = 2'd2;
  logic [DW-1:0] sampleIn = '0;
  logic irqA, irqB, validOut;
  logic [DW-1:0] sampleOut;
  logic [7:0] status;

  int nRun = 0, nFail = 0;
  bit done = 0;

  // reference state
  logic mIrqA = 0, mIrqB = 0, mValid = 0;
  int mCnt = 0;
  logic [DW-1:0] mSamp = '0;
  logic [2:0] mStk = '0;
  string sampTag = "R12";

  always #5 clk = ~clk;

  rx_event_irq #(.DATA_W(DW), .HOLD_0(H0), .HOLD_1(H1), .HOLD_2(H2), .HOLD_3(H3)) u0 (
    .clk(clk), .rstN(rstN), .fsTick(fsTick), .lockLost(lockLost), .parErr(parErr),
    .nonPcm(nonPcm), .audioFlag(audioFlag), .validIn(validIn), .qChgEv(qChgEv),
    .csChgEv(csChgEv), .detChgEv(detChgEv), .maskIn(maskIn), .holdSel(holdSel),
    .rdStrobe(rdStrobe), .sampleIn(sampleIn), .irqA(irqA), .irqB(irqB),
    .sampleOut(sampleOut), .validOut(validOut), .status(status)
  );

  function automatic int holdLenOf(logic [1:0] s);
    case (s)
      2'd0: return H0;
      2'd1: return H1;
      2'd2: return H2;
      default: return H3;
    endcase
  endfunction

  task automatic check(string req, longint act, longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Advance the reference by one edge from the inputs now driven.
  task automatic modelEdge();
    logic actA, actB;
    int len;
    actA = (lockLost & ~maskIn[0]) | (parErr & ~maskIn[1]);
    actB = (nonPcm & ~maskIn[2]) | (audioFlag & ~maskIn[3]);
    len = holdLenOf(holdSel);
    if (actA) begin mIrqA = 1; mCnt = 0; end
    else if (mIrqA) begin
      if (len == 0) begin mIrqA = 0; mCnt = 0; end
      else if (fsTick) begin
        if (mCnt + 1 >= len) begin mIrqA = 0; mCnt = 0; end
        else mCnt = mCnt + 1;
      end
    end
    mIrqB = actB;
    mValid = validIn & ~lockLost;
    if (lockLost) begin mSamp = '0; sampTag = "R9"; end
    else if (fsTick && !parErr) begin mSamp = sampleIn; sampTag = "R10"; end
    else sampTag = "R11";
    mStk = {detChgEv, csChgEv, qChgEv} | (mStk & {3{~rdStrobe}});
  endtask

  task automatic compareAll();
    check("R1/R2 irqA", irqA, mIrqA);
    check("R4 irqB", irqB, mIrqB);
    check({sampTag, " sampleOut"}, sampleOut, mSamp);
    check("R9/R10 validOut", validOut, mValid);
    check("R6 live status", status[4:0],
          {validIn, audioFlag, nonPcm, parErr, lockLost});
    check("R7 sticky status", status[7:5], mStk);
  endtask

  // Inputs set by the caller are taken at the next edge; compare at the next negedge.
  task automatic tick();
    modelEdge();
    @(negedge clk);
    compareAll();
    qChgEv = 0; csChgEv = 0; detChgEv = 0; rdStrobe = 0; fsTick = 0;
  endtask

  initial begin
    int ticksSeen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R12: outputs after reset
    check("R12 irqA", irqA, 0);
    check("R12 irqB", irqB, 0);
    check("R12 sampleOut", sampleOut, 0);
    check("R12 validOut", validOut, 0);
    check("R12 sticky", status[7:5], 0);

    // R2/R3: select 2 holds for H2 strobes
    holdSel = 2'd2;
    lockLost = 1; tick(); tick();
    lockLost = 0;
    ticksSeen = 0;
    for (int i = 0; i < 40; i++) begin
      fsTick = (i % 2 == 0);
      if (fsTick) ticksSeen++;
      tick();
      if (ticksSeen < H2) check("R2 held during hold", irqA, 1);
    end
    check("R2 released after hold", irqA, 0);

    // R2: restart mid-hold
    parErr = 1; tick(); parErr = 0;
    for (int i = 0; i < H2 - 2; i++) begin fsTick = 1; tick(); end
    parErr = 1; tick(); parErr = 0;
    for (int i = 0; i < H2 - 1; i++) begin fsTick = 1; tick(); end
    check("R2 restart keeps irqA high", irqA, 1);
    fsTick = 1; tick();
    check("R2 release after restart", irqA, 0);

    // R3: select 0 releases at once, select 3 holds H3
    holdSel = 2'd0; lockLost = 1; tick(); lockLost = 0; tick();
    check("R3 zero hold", irqA, 0);
    holdSel = 2'd3; lockLost = 1; tick(); lockLost = 0;
    for (int i = 0; i < H3 - 1; i++) begin fsTick = 1; tick(); end
    check("R3 long hold still high", irqA, 1);
    fsTick = 1; tick();
    check("R3 long hold done", irqA, 0);

    // R5: masked flags raise nothing but still show in status
    maskIn = 4'b1111; lockLost = 1; nonPcm = 1; tick(); tick();
    check("R5 masked irqA", irqA, 0);
    check("R5 masked irqB", irqB, 0);
    check("R5 status shows masked lockLost", status[0], 1);
    lockLost = 0; nonPcm = 0; maskIn = '0; tick();

    // R8: event and read together
    csChgEv = 1; tick();
    csChgEv = 1; rdStrobe = 1; tick();
    check("R8 event beats read", status[6], 1);
    rdStrobe = 1; tick();
    check("R7 read clears", status[6], 0);

    // R10/R11/R9: load, repeat under parity, zero on lock loss
    sampleIn = 16'hA5C3; fsTick = 1; tick();
    check("R10 load", sampleOut, 16'hA5C3);
    parErr = 1; sampleIn = 16'h1234; fsTick = 1; tick();
    check("R11 repeat", sampleOut, 16'hA5C3);
    parErr = 0; lockLost = 1; tick();
    check("R9 mute", sampleOut, 0);
    lockLost = 0;
    for (int i = 0; i < 30; i++) begin fsTick = (i % 3 == 0); tick(); end

    // random phase, fixed seed
    void'($urandom(32'h5EED_0A11));
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(99) < 1) lockLost = ~lockLost;
      if ($urandom_range(99) < 2) parErr = ~parErr;
      if ($urandom_range(99) < 3) nonPcm = ~nonPcm;
      if ($urandom_range(99) < 3) audioFlag = ~audioFlag;
      if ($urandom_range(99) < 5) validIn = ~validIn;
      if ($urandom_range(999) < 5) maskIn = 4'($urandom);
      if ($urandom_range(999) < 3) holdSel = 2'($urandom);
      fsTick = ($urandom_range(2) == 0);
      sampleIn = DW'($urandom);
      qChgEv = ($urandom_range(99) < 3);
      csChgEv = ($urandom_range(99) < 3);
      detChgEv = ($urandom_range(99) < 3);
      rdStrobe = ($urandom_range(99) < 5);
      tick();
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #(10 * 150000);
    if (!done) begin
      done = 1;
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule